// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block receives clocked-serial data as the bus master. It drives the shift clock out on `sclk_o` and reads the far end's data on `sdi_i`. A one-cycle baud tick is divided by four. Within each group of four ticks, the first tick raises the clock, the second samples the data pin and the third shifts the sample in and lowers the clock again. The far-end transmitter therefore changes data on the falling edge, and the receiver captures on the rising edge.

Software starts a frame by pulsing `en_set_i`. The frame format comes from the configuration inputs and is latched when the frame starts: 7 or 8 data bits sent LSB first, then an optional parity bit, then an optional multiprocessor flag bit. When the frame ends, the data word goes to a buffer register and the overrun and parity flags are updated. An interrupt request is then held until the next instruction-start strobe. In multiprocessor mode with the filter enabled, a frame whose flag bit is 0 is dropped silently.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, `free_o`=1, `sclk_o`=1, `en_o`=0, `buf_o`=0, and `ovr_o`, `perr_o`, `irq_o` and `irq_flag_o` are all 0.
- R2: A pulse on `en_set_i` while idle makes `en_o`=1 and `free_o`=0 on the next clock. A pulse on `en_set_i` while a frame is in progress has no effect, and no second frame follows.
- R3: Baud ticks are numbered from reset, starting at 1. `sclk_o` falls only on a tick whose number mod 4 is 3, and it rises on the next tick. A frame produces exactly N falling edges, where N = data length + parity enable + multiprocessor enable. `sclk_o` is high whenever the block is idle.
- R4: The data pin is sampled once per bit, on the tick after the rising edge. Bits arrive in this order: data bits LSB first, then the parity bit if parity is enabled, then the flag bit if multiprocessor mode is on.
- R5: One clock after the final shift tick, the data is loaded into `buf_o`, with bit 7 set to 0 in 7-bit mode. On the same clock `free_o` returns to 1 and `en_o` is cleared.
- R6: With parity enabled, `par_odd_i`=0 selects even parity: the data bits plus the parity bit carry an even number of ones. `par_odd_i`=1 selects odd parity. A mismatch sets `perr_o`, which stays set until `err_clr_i` is pulsed.
- R7: `ovr_o` is set when an accepted frame completes and the buffer has not been read since the previous load. A `buf_rd_i` pulse marks the buffer as read. An `err_clr_i` pulse clears `ovr_o`.
- R8: After an accepted frame, `irq_o` pulses for exactly one cycle, on the clock after the next `insn_start_i` strobe. `irq_flag_o` rises with that pulse and stays set until `irq_ack_i` is pulsed.
- R9: With `mp_en_i`=1 and `mp_filt_i`=1, a frame whose flag bit is 0 leaves `buf_o` and all flags unchanged and raises no interrupt. A frame whose flag bit is 1 is accepted. With `mp_filt_i`=0, every frame is accepted.
- R10: The configuration inputs are captured when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle baud-rate tick |
| en_set_i | input | 1 | Software pulse that starts a frame |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| mp_en_i | input | 1 | Multiprocessor flag bit present |
| mp_filt_i | input | 1 | Drop frames whose flag bit is 0 |
| sdi_i | input | 1 | Serial data in |
| buf_rd_i | input | 1 | Pulse: software read of the buffer |
| err_clr_i | input | 1 | Pulse: clear overrun and parity flags |
| insn_start_i | input | 1 | Instruction-start strobe |
| irq_ack_i | input | 1 | Pulse: clear the interrupt flag |
| sclk_o | output | 1 | Shift clock to the far end |
| free_o | output | 1 | 1 when no frame is in progress |
| en_o | output | 1 | Receive-enable bit, cleared by hardware |
| buf_o | output | 8 | Received data buffer |
| ovr_o | output | 1 | Overrun flag |
| perr_o | output | 1 | Parity error flag |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_flag_o | output | 1 | Sticky interrupt request flag |

## Verification
The failures show up in a few distinct ways:
- **Bit counter or phase counter.** An error here shows within a single frame: the number of `sclk_o` falling edges is wrong, or a falling edge lands on the wrong tick. The bench checks the tick position of every edge as it happens.
- **Field extraction.** A wrong parity or flag-bit position shows at completion: a wrong `buf_o` value, a wrong `perr_o`, or an interrupt that should have been suppressed.
- **Unread tracking or latched configuration.** Stale state here only becomes visible one frame later, as a missing or spurious `ovr_o`. It also shows as a wrong edge count when the inputs change during a frame.
- **Interrupt alignment.** An error shows as an `irq_o` pulse that does not follow a strobe by exactly one clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DMAX     = 8;
  localparam int FMAX     = DMAX + 2;
  localparam int CW       = $clog2(FMAX + 1);
  localparam int DIV      = 4;
  localparam int RISE_PH  = 0;
  localparam int SMP_PH   = 1;
  localparam int SHF_PH   = 2;

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic mp_en;
    logic mp_filt;
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER, ST_DONE} st_e;

  function automatic logic [CW-1:0] data_len(cfg_t c);
    return c.len8 ? CW'(DMAX) : CW'(DMAX - 1);
  endfunction

  function automatic logic [CW-1:0] frame_bits(cfg_t c);
    return data_len(c) + CW'(c.par_en) + CW'(c.mp_en);
  endfunction
endpackage

// File: rtl/srx_phase.sv
module srx_phase #(
  parameter int DIV     = 4,
  parameter int RISE_PH = 0,
  parameter int SMP_PH  = 1,
  parameter int SHF_PH  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o,
  output logic smp_o,
  output logic shf_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (tick_i)  ph_q <= (ph_q == PW'(DIV - 1)) ? '0 : ph_q + 1'b1;
  end

  assign rise_o = tick_i && (ph_q == PW'(RISE_PH));
  assign smp_o  = tick_i && (ph_q == PW'(SMP_PH));
  assign shf_o  = tick_i && (ph_q == PW'(SHF_PH));
endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import srx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  cfg_t            cfg_i,
  input  logic            rise_i,
  input  logic            smp_i,
  input  logic            shf_i,
  input  logic            sdi_i,
  output logic            sclk_o,
  output logic            busy_o,
  output logic            done_o,
  output cfg_t            cfg_o,
  output logic [FMAX-1:0] frame_o
);
  st_e             st_q;
  logic [CW-1:0]   cnt_q;
  logic            smp_q;
  logic            sclk_q;
  logic [FMAX-1:0] sreg_q;
  cfg_t            cfg_q;
  logic            last;

  assign last = (cnt_q == frame_bits(cfg_q) - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      smp_q  <= 1'b0;
      sclk_q <= 1'b1;
      sreg_q <= '0;
      cfg_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cfg_q  <= cfg_i;
          sreg_q <= '0;
          st_q   <= ST_WAIT;
        end
        ST_WAIT: if (shf_i) begin
          sclk_q <= 1'b0;
          cnt_q  <= '0;
          st_q   <= ST_XFER;
        end
        ST_XFER: begin
          if (rise_i) sclk_q <= 1'b1;
          if (smp_i)  smp_q  <= sdi_i;
          if (shf_i) begin
            sreg_q[cnt_q] <= smp_q;
            if (last) st_q <= ST_DONE;
            else begin
              sclk_q <= 1'b0;
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o  = sclk_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign cfg_o   = cfg_q;
  assign frame_o = sreg_q;
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  cfg_t            cfg_i,
  input  logic [FMAX-1:0] frame_i,
  input  logic            buf_rd_i,
  input  logic            err_clr_i,
  output logic [DMAX-1:0] buf_o,
  output logic            ovr_o,
  output logic            perr_o,
  output logic            acc_o
);
  logic [DMAX-1:0] data;
  logic [CW-1:0]   dl, mi;
  logic            pbit, mpc, par_bad;
  logic            unread_q, ovr_q, perr_q;
  logic [DMAX-1:0] buf_q;

  always_comb begin
    dl      = data_len(cfg_i);
    mi      = dl + CW'(cfg_i.par_en);
    data    = cfg_i.len8 ? frame_i[DMAX-1:0] : {1'b0, frame_i[DMAX-2:0]};
    pbit    = frame_i[dl];
    mpc     = frame_i[mi];
    par_bad = cfg_i.par_en && ((^data ^ pbit) != cfg_i.par_odd);
  end

  // Filtered frames neither load nor interrupt
  assign acc_o = done_i && !(cfg_i.mp_en && cfg_i.mp_filt && !mpc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q    <= '0;
      unread_q <= 1'b0;
      ovr_q    <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      if (acc_o) begin
        buf_q    <= data;
        unread_q <= 1'b1;
      end else if (buf_rd_i) begin
        unread_q <= 1'b0;
      end
      if (acc_o && unread_q) ovr_q <= 1'b1;
      else if (err_clr_i)    ovr_q <= 1'b0;
      if (acc_o && par_bad)  perr_q <= 1'b1;
      else if (err_clr_i)    perr_q <= 1'b0;
    end
  end

  assign buf_o  = buf_q;
  assign ovr_o  = ovr_q;
  assign perr_o = perr_q;
endmodule

// File: rtl/srx_irq.sv
module srx_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic insn_start_i,
  input  logic irq_ack_i,
  output logic irq_o,
  output logic irq_flag_o
);
  logic pend_q, irq_q, flag_q, fire;

  assign fire = pend_q && insn_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (req_i)     pend_q <= 1'b1;
      else if (fire) pend_q <= 1'b0;
      irq_q <= fire;
      if (fire)           flag_q <= 1'b1;
      else if (irq_ack_i) flag_q <= 1'b0;
    end
  end

  assign irq_o      = irq_q;
  assign irq_flag_o = flag_q;
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import srx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            baud_tick_i,
  input  logic            en_set_i,
  input  logic            len8_i,
  input  logic            par_en_i,
  input  logic            par_odd_i,
  input  logic            mp_en_i,
  input  logic            mp_filt_i,
  input  logic            sdi_i,
  input  logic            buf_rd_i,
  input  logic            err_clr_i,
  input  logic            insn_start_i,
  input  logic            irq_ack_i,
  output logic            sclk_o,
  output logic            free_o,
  output logic            en_o,
  output logic [DMAX-1:0] buf_o,
  output logic            ovr_o,
  output logic            perr_o,
  output logic            irq_o,
  output logic            irq_flag_o
);
  logic            rise, smp, shf, busy, done, acc;
  cfg_t            cfg_in, cfg_q;
  logic [FMAX-1:0] frame;

  assign cfg_in = '{len8: len8_i, par_en: par_en_i, par_odd: par_odd_i,
                    mp_en: mp_en_i, mp_filt: mp_filt_i};

  srx_phase #(.DIV(DIV), .RISE_PH(RISE_PH), .SMP_PH(SMP_PH), .SHF_PH(SHF_PH)) u_phase (
    .clk_i, .rst_ni, .tick_i(baud_tick_i), .rise_o(rise), .smp_o(smp), .shf_o(shf)
  );

  srx_shift u_shift (
    .clk_i, .rst_ni, .start_i(en_set_i && !busy), .cfg_i(cfg_in),
    .rise_i(rise), .smp_i(smp), .shf_i(shf), .sdi_i,
    .sclk_o, .busy_o(busy), .done_o(done), .cfg_o(cfg_q), .frame_o(frame)
  );

  srx_status u_status (
    .clk_i, .rst_ni, .done_i(done), .cfg_i(cfg_q), .frame_i(frame),
    .buf_rd_i, .err_clr_i, .buf_o, .ovr_o, .perr_o, .acc_o(acc)
  );

  srx_irq u_irq (
    .clk_i, .rst_ni, .req_i(acc), .insn_start_i, .irq_ack_i, .irq_o, .irq_flag_o
  );

  assign free_o = !busy;
  assign en_o   = busy;
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_set_i,
  input logic       insn_start_i,
  input logic       sclk_o,
  input logic       free_o,
  input logic       ovr_o,
  input logic       irq_o,
  input logic       irq_flag_o
);
  // R3
  idle_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |-> sclk_o);
  // R3
  fall_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> !free_o);
  // R2
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(free_o) |-> $past(en_set_i));
  // R7
  ovr_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $rose(free_o));
  // R8
  irq_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(insn_start_i));
  // R8
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  flag_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag_o) |-> irq_o);
endmodule

bind sync_rx_master srx_chk u_chk (
  .clk_i, .rst_ni, .en_set_i, .insn_start_i, .sclk_o, .free_o, .ovr_o, .irq_o, .irq_flag_o
);

// File: tb/tb_sync_rx_master.sv
module tb_sync_rx_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic baud = 0, en_set = 0, len8 = 1, par_en = 0, par_odd = 0, mp_en = 0, mp_filt = 0;
  logic sdi = 0, buf_rd = 0, err_clr = 0, ins = 0, irq_ack = 0;
  logic sclk, free, en, ovr, perr, irq, irq_flag;
  logic [7:0] buf_v;

  int n_chk = 0, n_err = 0, tcount = 0, falls = 0, sidx = 0, irq_cnt = 0;
  logic [9:0] sbits = '0;
  logic ins_prev = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] d;
    logic perr;
    logic ovr;
    logic rd;
    logic clr;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_rx_master dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(baud), .en_set_i(en_set),
    .len8_i(len8), .par_en_i(par_en), .par_odd_i(par_odd), .mp_en_i(mp_en),
    .mp_filt_i(mp_filt), .sdi_i(sdi), .buf_rd_i(buf_rd), .err_clr_i(err_clr),
    .insn_start_i(ins), .irq_ack_i(irq_ack), .sclk_o(sclk), .free_o(free),
    .en_o(en), .buf_o(buf_v), .ovr_o(ovr), .perr_o(perr), .irq_o(irq),
    .irq_flag_o(irq_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // baud tick every 4 clocks
  initial begin
    wait (rst_n);
    forever begin
      repeat (3) @(posedge clk);
      #1 baud = 1; tcount++;
      @(posedge clk);
      #1 baud = 0;
    end
  end

  // instruction-start strobe every 5 clocks
  initial begin
    wait (rst_n);
    forever begin
      repeat (4) @(posedge clk);
      #1 ins = 1;
      @(posedge clk);
      #1 ins = 0;
    end
  end

  // far-end transmitter: new bit on each falling clock edge
  initial begin
    forever begin
      @(negedge sclk);
      if (rst_n) begin
        chk(tcount % 4 == 3, "R3 fall on third tick", tcount % 4, 3);
        if (sidx < 10) sdi = sbits[sidx];
        sidx++;
        falls++;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (irq) begin
        irq_cnt++;
        chk(ins_prev == 1'b1, "R8 irq follows strobe", ins_prev, 1);
        chk(irq_flag == 1'b1, "R8 flag with irq", irq_flag, 1);
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected irq", 1, 0);
        end else begin
          e = q.pop_front();
          chk(buf_v == e.d, "R4/R5 buffer", buf_v, e.d);
          chk(perr == e.perr, "R6 parity flag", perr, e.perr);
          chk(ovr == e.ovr, "R7 overrun flag", ovr, e.ovr);
          @(posedge clk);
          #1 irq_ack = 1; buf_rd = e.rd; err_clr = e.clr;
          @(posedge clk);
          #1 irq_ack = 0; buf_rd = 0; err_clr = 0;
          chk(irq_flag == 1'b0, "R8 flag cleared by ack", irq_flag, 0);
        end
      end
      ins_prev = ins;
    end
  end

  task automatic run(input logic [7:0] d, input logic l8, input logic pe, input logic po,
                     input logic me, input logic mf, input logic mpc, input logic flip,
                     input logic acc, input logic rd, input logic clr,
                     input logic ep, input logic eo, input logic tweak);
    int dlen, nb, pre_irq;
    logic [7:0] dm, pre_buf;
    logic p;
    dlen = l8 ? 8 : 7;
    nb   = dlen + int'(pe) + int'(me);
    dm   = l8 ? d : {1'b0, d[6:0]};
    sbits = '0;
    for (int i = 0; i < dlen; i++) sbits[i] = d[i];
    p = (^dm) ^ po ^ flip;
    if (pe) sbits[dlen] = p;
    if (me) sbits[dlen + int'(pe)] = mpc;
    sidx = 0; falls = 0;
    len8 = l8; par_en = pe; par_odd = po; mp_en = me; mp_filt = mf;
    pre_irq = irq_cnt; pre_buf = buf_v;
    if (acc) q.push_back('{d: dm, perr: ep, ovr: eo, rd: rd, clr: clr});
    @(posedge clk); #1 en_set = 1;
    @(posedge clk); #1 en_set = 0;
    chk(!free && en, "R2 start", {free, en}, 2'b01);
    if (tweak) begin
      // R10: flip config mid-frame; R2: second start ignored
      len8 = ~l8; par_en = ~pe; mp_en = ~me; par_odd = ~po;
      repeat (20) @(posedge clk);
      #1 en_set = 1;
      @(posedge clk); #1 en_set = 0;
    end
    while (!free) begin @(posedge clk); #1; end
    chk(falls == nb, tweak ? "R10 edge count" : "R3 edge count", falls, nb);
    chk(sclk == 1'b1, "R3 idle high", sclk, 1);
    chk(en == 1'b0, "R5 enable cleared", en, 0);
    len8 = l8; par_en = pe; mp_en = me; par_odd = po;
    if (!acc) begin
      repeat (40) @(posedge clk);
      #1;
      chk(irq_cnt == pre_irq, "R9 no irq", irq_cnt - pre_irq, 0);
      chk(buf_v == pre_buf, "R9 buffer kept", buf_v, pre_buf);
      chk(irq_flag == 1'b0, "R9 flag clear", irq_flag, 0);
    end else begin
      while (q.size() != 0) @(posedge clk);
      repeat (6) @(posedge clk);
      #1;
    end
    if (tweak) chk(free == 1'b1, "R2 ignored start", free, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(free && sclk && !en, "R1 idle outputs", {free, sclk, en}, 3'b110);
    chk(buf_v == 8'h00, "R1 buffer", buf_v, 0);
    chk({ovr, perr, irq, irq_flag} == 4'b0, "R1 flags", {ovr, perr, irq, irq_flag}, 0);
    //   data   l8 pe po me mf mpc fl acc rd clr ep eo tw
    run(8'hA5, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);  // R4 8-bit
    run(8'hDB, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);  // R5 7-bit
    run(8'h3C, 1, 1, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);  // R6 even ok
    run(8'h96, 1, 1, 1, 0, 0, 0, 1, 1, 1, 0, 1, 0, 0);  // R6 odd bad
    run(8'h0F, 1, 1, 1, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);  // R6 sticky
    run(8'h70, 0, 1, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);  // R6 cleared, 7-bit
    run(8'h11, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);  // R7 left unread
    run(8'h22, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 0);  // R7 overrun
    run(8'h33, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);  // R7 cleared
    run(8'h44, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);  // R9 dropped
    run(8'h55, 1, 1, 0, 1, 1, 1, 0, 1, 1, 1, 0, 0, 0);  // R9 accepted
    run(8'h66, 0, 0, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0);  // R9 filter off
    run(8'hC3, 1, 1, 1, 1, 0, 1, 0, 1, 1, 1, 0, 0, 1);  // R10 + R2
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end
endmodule